// File: doc/BRIEF.md
# Address-Window Event Filter

This block watches a stream of access events from a processor and reports, one cycle later, which of its table entries accept each event. An event carries a kind vector and a 16-bit address. Five kinds are defined: memory read, memory write, register read, register write, and execution of a reserved or illegal instruction. For the two register kinds the address field carries the register index, and it is compared exactly like a memory address.

Each of the eight entries holds a valid flag, a kind mask, a low bound and a high bound. An entry fires when it is valid, its mask shares at least one set bit with the event kind, and the address lies inside its inclusive window. All entries are checked in parallel and every entry that accepts the event fires, so one event can set several bits of the hit vector. Entries are written one whole record at a time through a single-cycle write port.

The block has no state machine. Its only sequencing is a two-phase cycle. In the first phase the event is compared against the table as it stood before the clock edge. In the second phase the registered hit vector is shown for exactly one cycle.

Top module: `evf_top`

## Requirements
- R1: After reset the hit vector is all zero and every entry is invalid, so no event fires any entry until one is written.
- R2: An entry is a candidate only if the bitwise AND of its mask and the event kind is nonzero. Kind bits are: bit 0 memory read, bit 1 memory write, bit 2 register read, bit 3 register write, bit 4 reserved/illegal instruction.
- R3: An entry fires only if low bound <= address <= high bound; both ends are inclusive.
- R4: Every entry that accepts an event fires in the same hit vector. Bit i of the hit vector belongs to entry i, and matching does not stop at the first hit.
- R5: An entry whose valid flag is clear never fires. Writing a record with the valid flag at 0 disables the entry.
- R6: An entry whose low bound is greater than its high bound never fires.
- R7: The hit vector is registered. It shows the result of an event strobed on clock edge N from edge N to edge N+1, and it is zero after any edge on which no event was strobed.
- R8: A write replaces valid, mask, low and high of the addressed entry together. An event strobed on the same edge as a write is judged against the entry's previous contents.
- R9: For register-read and register-write events, the address field is matched as a register index against the same window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one entry record |
| cfg_slot | input | 3 | Index of the entry to write |
| cfg_valid | input | 1 | Valid flag of the record |
| cfg_mask | input | 5 | Kind mask of the record |
| cfg_lo | input | 16 | Inclusive low bound |
| cfg_hi | input | 16 | Inclusive high bound |
| ev_strobe | input | 1 | An event is present this cycle |
| ev_kind | input | 5 | Event kind vector |
| ev_addr | input | 16 | Memory address or register index |
| hit_vec | output | 8 | Registered per-entry hit flags |

## Verification
A corrupted entry shows up as a wrong hit bit on the first event that falls near that entry's bounds or kinds. The bench therefore aims its events at a narrow address space, so that the edges of every window are crossed often. A write that is lost, or that goes to the wrong entry, appears in the hit vector one cycle after the next relevant event. A late or stuck output register appears at once as a nonzero hit vector on a cycle with no strobe. The window edges, overlapping entries, inverted bounds and a write coinciding with an event are each driven directly.

// File: rtl/evf_pkg.sv
package evf_pkg;
    localparam int unsigned EVF_KIND_W = 5;

    typedef enum logic [2:0] {
        KB_MEM_RD  = 3'd0,
        KB_MEM_WR  = 3'd1,
        KB_REG_RD  = 3'd2,
        KB_REG_WR  = 3'd3,
        KB_ILLEGAL = 3'd4
    } kind_bit_e;

    typedef logic [EVF_KIND_W-1:0] kind_vec_t;
endpackage

// File: rtl/evf_wr_decode.sv
module evf_wr_decode #(
    parameter int unsigned NUM_SLOTS = 8,
    localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IDX_W-1:0]     slot,
    output logic [NUM_SLOTS-1:0] sel
);
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (we && (slot == IDX_W'(i))) sel[i] = 1'b1;
        end
    end

    // R8: a write touches at most one entry
    a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && slot < NUM_SLOTS) |-> ($countones(sel) == 1));
endmodule

// File: rtl/evf_slot.sv
module evf_slot #(
    parameter int unsigned KIND_W = evf_pkg::EVF_KIND_W,
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_valid,
    input  logic [KIND_W-1:0] wr_mask,
    input  logic [ADDR_W-1:0] wr_lo,
    input  logic [ADDR_W-1:0] wr_hi,
    input  logic              ev_strobe,
    input  logic [KIND_W-1:0] ev_kind,
    input  logic [ADDR_W-1:0] ev_addr,
    output logic              hit_q
);
    logic              valid_q;
    logic [KIND_W-1:0] mask_q;
    logic [ADDR_W-1:0] lo_q, hi_q;
    logic              kind_ok, above_lo, below_hi, hit_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            mask_q  <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else if (wr_en) begin
            valid_q <= wr_valid;
            mask_q  <= wr_mask;
            lo_q    <= wr_lo;
            hi_q    <= wr_hi;
        end
    end

    always_comb begin
        kind_ok  = |(mask_q & ev_kind);
        above_lo = (ev_addr >= lo_q);
        below_hi = (ev_addr <= hi_q);
        hit_d    = ev_strobe & valid_q & kind_ok & above_lo & below_hi;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit_d;
    end

    // R5: invalid entry stays silent
    a_r5_invalid_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |=> !hit_q);
    // R6: inverted window stays silent
    a_r6_inverted_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_q > hi_q) |=> !hit_q);
    // R2: no shared kind bit, no hit
    a_r2_kind_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_q & ev_kind) == '0) |=> !hit_q);
    // R3: address outside the window, no hit
    a_r3_outside_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_addr < lo_q) || (ev_addr > hi_q)) |=> !hit_q);
    // R8: the whole record is taken on a write
    a_r8_record_taken: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q == $past(wr_valid) && mask_q == $past(wr_mask)
                   && lo_q == $past(wr_lo) && hi_q == $past(wr_hi)));
endmodule

// File: rtl/evf_top.sv
module evf_top #(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned KIND_W    = evf_pkg::EVF_KIND_W,
    parameter int unsigned ADDR_W    = 16,
    localparam int unsigned IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_slot,
    input  logic                 cfg_valid,
    input  logic [KIND_W-1:0]    cfg_mask,
    input  logic [ADDR_W-1:0]    cfg_lo,
    input  logic [ADDR_W-1:0]    cfg_hi,
    input  logic                 ev_strobe,
    input  logic [KIND_W-1:0]    ev_kind,
    input  logic [ADDR_W-1:0]    ev_addr,
    output logic [NUM_SLOTS-1:0] hit_vec
);
    logic [NUM_SLOTS-1:0] wr_sel;
    logic [NUM_SLOTS-1:0] slot_hit;

    evf_wr_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cfg_we),
        .slot (cfg_slot),
        .sel  (wr_sel)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        evf_slot #(.KIND_W(KIND_W), .ADDR_W(ADDR_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_sel[g]),
            .wr_valid (cfg_valid),
            .wr_mask  (cfg_mask),
            .wr_lo    (cfg_lo),
            .wr_hi    (cfg_hi),
            .ev_strobe(ev_strobe),
            .ev_kind  (ev_kind),
            .ev_addr  (ev_addr),
            .hit_q    (slot_hit[g])
        );
    end

    assign hit_vec = slot_hit;

    // R7: no strobe on an edge means an empty hit vector after it
    a_r7_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_strobe |=> (hit_vec == '0));
    // R2: an event with no kind bits fires nothing
    a_r2_empty_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_kind == '0) |=> (hit_vec == '0));
endmodule

// File: tb/evf_top_tb.sv
`timescale 1ns/1ps
module evf_top_tb;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_slot = '0;
    logic        cfg_valid = 1'b0;
    logic [4:0]  cfg_mask = '0;
    logic [15:0] cfg_lo = '0, cfg_hi = '0;
    logic        ev_strobe = 1'b0;
    logic [4:0]  ev_kind = '0;
    logic [15:0] ev_addr = '0;
    logic [7:0]  hit_vec;

    int applied = 0;
    int miscompares = 0;

    logic        m_valid [N];
    logic [4:0]  m_mask  [N];
    logic [15:0] m_lo    [N];
    logic [15:0] m_hi    [N];

    always #5 clk = ~clk;

    evf_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_valid(cfg_valid), .cfg_mask(cfg_mask), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .ev_strobe(ev_strobe), .ev_kind(ev_kind), .ev_addr(ev_addr), .hit_vec(hit_vec)
    );

    function automatic logic [7:0] expect_hits(logic stb, logic [4:0] k, logic [15:0] a);
        logic [7:0] r = '0;
        for (int i = 0; i < N; i++)
            r[i] = stb && m_valid[i] && ((m_mask[i] & k) != 0) && (a >= m_lo[i]) && (a <= m_hi[i]);
        return r;
    endfunction

    task automatic check(string req, logic [7:0] exp);
        applied++;
        if (hit_vec !== exp) begin
            miscompares++;
            $display("FAIL %s: hit_vec=%h expected=%h", req, hit_vec, exp);
        end
    endtask

    // drive at negedge, expected from pre-write table, compare at next negedge
    task automatic step(string req, logic we, logic [2:0] s, logic v, logic [4:0] m,
                        logic [15:0] lo, logic [15:0] hi,
                        logic stb, logic [4:0] k, logic [15:0] a);
        logic [7:0] exp;
        cfg_we = we; cfg_slot = s; cfg_valid = v; cfg_mask = m; cfg_lo = lo; cfg_hi = hi;
        ev_strobe = stb; ev_kind = k; ev_addr = a;
        exp = expect_hits(stb, k, a);
        if (we) begin
            m_valid[s] = v; m_mask[s] = m; m_lo[s] = lo; m_hi[s] = hi;
        end
        @(negedge clk);
        check(req, exp);
    endtask

    task automatic wr(logic [2:0] s, logic v, logic [4:0] m, logic [15:0] lo, logic [15:0] hi);
        step("R8", 1'b1, s, v, m, lo, hi, 1'b0, 5'd0, 16'd0);
    endtask

    task automatic ev(string req, logic [4:0] k, logic [15:0] a);
        step(req, 1'b0, 3'd0, 1'b0, 5'd0, 16'd0, 16'd0, 1'b1, k, a);
    endtask

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 1'b0; m_mask[i] = '0; m_lo[i] = '0; m_hi[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", 8'h00);
        ev("R1 empty table", 5'h1f, 16'h0000);
        ev("R1 empty table", 5'h1f, 16'hffff);

        // slot 0: memory reads (bit 0) in 0x0100..0x01ff
        wr(3'd0, 1'b1, 5'b00001, 16'h0100, 16'h01ff);
        ev("R3 low edge", 5'b00001, 16'h0100);
        ev("R3 high edge", 5'b00001, 16'h01ff);
        ev("R3 below", 5'b00001, 16'h00ff);
        ev("R3 above", 5'b00001, 16'h0200);
        ev("R2 kind miss (mem write bit 1)", 5'b00010, 16'h0150);
        // R7: result held exactly one cycle, zero with no strobe
        ev("R7 strobe", 5'b00001, 16'h0150);
        step("R7 idle after hit", 1'b0, 3'd0, 1'b0, 5'd0, 16'd0, 16'd0, 1'b0, 5'b00001, 16'h0150);

        // slot 1 overlaps slot 0, takes reads and writes
        wr(3'd1, 1'b1, 5'b00011, 16'h0180, 16'h0300);
        ev("R4 both fire", 5'b00001, 16'h0190);
        ev("R4 only slot 1", 5'b00010, 16'h0190);

        // slot 2 inverted bounds
        wr(3'd2, 1'b1, 5'b11111, 16'h0500, 16'h0400);
        ev("R6 inverted", 5'b11111, 16'h0450);
        ev("R6 inverted at lo", 5'b11111, 16'h0500);

        // slot 3: register reads/writes (bits 2,3) over indices 2..5
        wr(3'd3, 1'b1, 5'b01100, 16'h0002, 16'h0005);
        ev("R9 reg read index", 5'b00100, 16'h0005);
        ev("R9 reg write index", 5'b01000, 16'h0002);
        ev("R9 index outside", 5'b00100, 16'h0006);

        // slot 4: illegal instruction, single address window
        wr(3'd4, 1'b1, 5'b10000, 16'hffff, 16'hffff);
        ev("R3 single address", 5'b10000, 16'hffff);

        // R8: write coinciding with event sees the old record
        step("R8 same-edge write", 1'b1, 3'd0, 1'b0, 5'b00001, 16'h0100, 16'h01ff,
             1'b1, 5'b00001, 16'h0120);
        ev("R5 invalidated", 5'b00001, 16'h0120);
        wr(3'd0, 1'b1, 5'b00001, 16'h0000, 16'h0010);
        ev("R8 new record", 5'b00001, 16'h0010);
        ev("R5 other slots", 5'b11111, 16'h7000);

        // random traffic over a narrow address space
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] lo, hi;
            lo = 16'($urandom_range(0, 63));
            hi = 16'($urandom_range(0, 63));
            if (($urandom % 8) == 0)
                step("R2/R3/R4/R5/R6 random", 1'b1, 3'($urandom), 1'($urandom % 4 != 0),
                     5'($urandom), lo, hi, 1'($urandom), 5'(1 << ($urandom % 5)),
                     16'($urandom_range(0, 63)));
            else
                step("R4/R7 random", 1'b0, 3'd0, 1'b0, 5'd0, 16'd0, 16'd0,
                     1'($urandom % 4 != 0), 5'($urandom), 16'($urandom_range(0, 63)));
        end

        // R1: reset wipes the table
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
        check("R1 after re-reset", 8'h00);
        ev("R1 table cleared", 5'h1f, 16'h0010);

        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end
endmodule